// File: doc/BRIEF.md
# Parallel Word Bit Error Rate Tester

This block is a pattern source and an error checker for an 8-bit parallel link, for example the parallel side of a serializer and deserializer pair. The generator hands one word per accepted transfer to the transmit path. Bit 0 of each word carries a single-bit pseudo-random sequence. Bits 7 to 1 carry a separate 7-bit pseudo-random word sequence that steps once per word. The checker takes the recovered words. It locks onto the bit-0 lane and uses that lane to rebuild the word sequence. It then compares each received word with the word it expects and accumulates the number of differing bits. It also counts the number of words it has compared, so that the bit error rate equals the error count divided by eight times the word count.

Bit 0 serves only for alignment. A long run of bit-0 mismatches while locked is read as a lost or added word (a slip). The slip is counted, lock is dropped and the checker searches for alignment again. A pulse on `start` clears every counter and restarts both pseudo-random sources from their seeds.

Both word buses are valid/ready streams. On the transmit side, the word on `tx_data` and the generator state are held for as long as `tx_valid` is high and `tx_ready` is low. The generator advances only on a cycle where both are high. On the receive side the checker never applies back-pressure: `rx_ready` is always high, and every cycle with `rx_valid` high delivers one word.

Top module: `bert_core`

## Requirements
- R1: While reset is held and after it, `tx_valid` and `sync_lock` are low and all three counters read zero. After a `start` pulse, `tx_valid` is high and the counters read zero.
- R2: The bit-0 source is a 7-bit shift register with polynomial x^7+x^6+1 and seed 7'h01. The new bit is state[6] XOR state[5]; it appears on `tx_data[0]` and is shifted into state[0]. Bits 7:1 carry the state of a second register with the same polynomial and seed 7'h5A. The first word after `start` is 8'hB4 and the second is 8'h6A.
- R3: While `tx_valid` is high and `tx_ready` is low, `tx_data` does not change. Each handshake advances both sources by exactly one step.
- R4: `rx_ready` is always high. Cycles with `rx_valid` low leave all checker state and counters unchanged.
- R5: From an unlocked state, `sync_lock` rises after 23 valid words with a clean bit-0 lane: 7 words that seed the predictor, then 16 consecutive correct predictions. It is visible one clock after the 23rd word. The word-sequence reference is taken from bits 7:1 of that 23rd word.
- R6: While `sync_lock` is low, the error and word counts do not change, whatever the received data.
- R7: Every valid word received while locked adds 1 to `word_count` and adds to `bit_err_count` the number of bits that differ from the expected word.
- R8: While locked, a run of fewer than 4 consecutive bit-0 mismatches counts as bit errors only. Lock is held, and the bit-0 predictor keeps following its own sequence.
- R9: While locked, the 4th consecutive bit-0 mismatch adds 1 to `slip_count` and clears `sync_lock`. That word is still counted. Alignment then restarts as in R5.
- R10: All counters saturate at all ones instead of wrapping.
- R11: `start` clears the counters and lock and reloads both seeds. It takes priority over a handshake or a received word in the same cycle.
- R12: In a clean loopback, `bit_err_count` stays zero and `slip_count` stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Clear counters, drop lock, reseed generator |
| tx_data | output | 8 | Generated word |
| tx_valid | output | 1 | Generated word available |
| tx_ready | input | 1 | Transmit path accepts the word |
| rx_data | input | 8 | Recovered word |
| rx_valid | input | 1 | Recovered word present |
| rx_ready | output | 1 | Always high |
| sync_lock | output | 1 | Checker aligned to the bit-0 lane |
| bit_err_count | output | 16 | Saturating count of bit errors |
| slip_count | output | 16 | Saturating count of detected slips |
| word_count | output | 16 | Saturating count of words compared while locked |

## Verification
Every result is registered. The counters and `sync_lock` reflect a received word one clock edge after the edge that accepts it. The next `tx_data` appears one edge after a handshake, and `start` acts at the edge where it is sampled. The bench drives words in a loopback, with a per-word error mask applied at falling edges. It queues the expected lock state, the three counts and, where it matters, the transmit word. The monitor compares them one nanosecond after the falling edge that follows the last accepted word, so that every register on the path has already taken its new value. Slip and lock timing are tested at the exact word counts: 22 against 23 words for lock, and 3 against 4 mismatches for a slip.

// File: rtl/bert_pkg.sv
package bert_pkg;
  localparam int WORD_W    = 8;
  localparam int PRBS_LEN  = 7;
  localparam int TAP_HI    = 7;
  localparam int TAP_LO    = 6;
  localparam int LOCK_RUN  = 16;
  localparam int SLIP_RUN  = 4;
  localparam int CNT_W     = 16;
  localparam logic [PRBS_LEN-1:0] PRBS_SEED = 7'h01;
  localparam logic [WORD_W-2:0]   WORD_SEED = 7'h5A;
endpackage

// File: rtl/bert_lfsr_step.sv
module bert_lfsr_step #(
  parameter int LEN   = 7,
  parameter int TAP_A = 7,
  parameter int TAP_B = 6
) (
  input  logic [LEN-1:0] state_i,
  output logic [LEN-1:0] state_o
);
  // Fibonacci step: the feedback bit lands in bit 0 and is the emitted bit.
  assign state_o = {state_i[LEN-2:0], state_i[TAP_A-1] ^ state_i[TAP_B-1]};
endmodule

// File: rtl/bert_gen.sv
module bert_gen
  import bert_pkg::*;
#(
  parameter int WIDTH = WORD_W,
  parameter int PLEN  = PRBS_LEN,
  parameter logic [PLEN-1:0]  P_SEED = PRBS_SEED,
  parameter logic [WIDTH-2:0] W_SEED = WORD_SEED
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             ready,
  output logic             valid,
  output logic [WIDTH-1:0] data
);
  localparam int LANE_W = WIDTH - 1;

  logic [PLEN-1:0]   p_q, p_nx;
  logic [LANE_W-1:0] w_q, w_nx;
  logic              run_q;

  bert_lfsr_step #(.LEN(PLEN),   .TAP_A(TAP_HI), .TAP_B(TAP_LO)) u_pstep (.state_i(p_q), .state_o(p_nx));
  bert_lfsr_step #(.LEN(LANE_W), .TAP_A(TAP_HI), .TAP_B(TAP_LO)) u_wstep (.state_i(w_q), .state_o(w_nx));

  assign valid = run_q;
  assign data  = {w_q, p_nx[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      p_q   <= P_SEED;
      w_q   <= W_SEED;
    end else if (start) begin
      run_q <= 1'b1;
      p_q   <= P_SEED;
      w_q   <= W_SEED;
    end else if (run_q && ready) begin
      p_q <= p_nx;
      w_q <= w_nx;
    end
  end
endmodule

// File: rtl/bert_sync.sv
module bert_sync
  import bert_pkg::*;
#(
  parameter int LEN   = PRBS_LEN,
  parameter int L_RUN = LOCK_RUN,
  parameter int S_RUN = SLIP_RUN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic in_valid,
  input  logic in_bit,
  output logic locked,
  output logic exp_bit,
  output logic lock_evt,
  output logic slip_evt
);
  localparam int FW = $clog2(LEN + 1);
  localparam int GW = $clog2(L_RUN);
  localparam int MW = $clog2(S_RUN);
  localparam logic [FW-1:0] FILL_FULL = FW'(LEN);
  localparam logic [GW-1:0] GOOD_LAST = GW'(L_RUN - 1);
  localparam logic [MW-1:0] MISS_LAST = MW'(S_RUN - 1);

  logic [LEN-1:0] c_q, c_nx;
  logic [FW-1:0]  fill_q;
  logic [GW-1:0]  good_q;
  logic [MW-1:0]  miss_q;
  logic           lock_q;
  logic           filled, match;

  bert_lfsr_step #(.LEN(LEN), .TAP_A(TAP_HI), .TAP_B(TAP_LO)) u_pred (.state_i(c_q), .state_o(c_nx));

  assign exp_bit  = c_nx[0];
  assign filled   = (fill_q == FILL_FULL);
  assign match    = (in_bit == exp_bit);
  assign locked   = lock_q;
  assign lock_evt = in_valid && !lock_q && filled && match && (good_q == GOOD_LAST);
  assign slip_evt = in_valid && lock_q && !match && (miss_q == MISS_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_q    <= '0;
      fill_q <= '0;
      good_q <= '0;
      miss_q <= '0;
      lock_q <= 1'b0;
    end else if (clear) begin
      fill_q <= '0;
      good_q <= '0;
      miss_q <= '0;
      lock_q <= 1'b0;
    end else if (in_valid) begin
      if (!lock_q) begin
        // Acquisition: track the received lane directly.
        c_q <= {c_q[LEN-2:0], in_bit};
        if (!filled) begin
          fill_q <= fill_q + 1'b1;
        end else if (match) begin
          if (good_q == GOOD_LAST) begin
            lock_q <= 1'b1;
            good_q <= '0;
            miss_q <= '0;
          end else begin
            good_q <= good_q + 1'b1;
          end
        end else begin
          good_q <= '0;
        end
      end else begin
        // Locked: free-run on the prediction, watch for a mismatch run.
        c_q <= c_nx;
        if (match) begin
          miss_q <= '0;
        end else if (miss_q == MISS_LAST) begin
          lock_q <= 1'b0;
          fill_q <= '0;
          good_q <= '0;
          miss_q <= '0;
        end else begin
          miss_q <= miss_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bert_sat_acc.sv
module bert_sat_acc #(
  parameter int W     = 16,
  parameter int INC_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             en,
  input  logic [INC_W-1:0] inc,
  output logic [W-1:0]     value
);
  logic [W:0] sum;

  assign sum = {1'b0, value} + (W+1)'(inc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      value <= '0;
    else if (clear)  value <= '0;
    else if (en)     value <= sum[W] ? {W{1'b1}} : sum[W-1:0];
  end
endmodule

// File: rtl/bert_core.sv
module bert_core
  import bert_pkg::*;
#(
  parameter int WIDTH = WORD_W,
  parameter int CW    = CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic [WIDTH-1:0] tx_data,
  output logic             tx_valid,
  input  logic             tx_ready,
  input  logic [WIDTH-1:0] rx_data,
  input  logic             rx_valid,
  output logic             rx_ready,
  output logic             sync_lock,
  output logic [CW-1:0]    bit_err_count,
  output logic [CW-1:0]    slip_count,
  output logic [CW-1:0]    word_count
);
  localparam int LANE_W = WIDTH - 1;
  localparam int POP_W  = $clog2(WIDTH + 1);

  logic              exp_bit, lock_evt, slip_evt, chk_word;
  logic [LANE_W-1:0] wref_q, wref_nx, rx_lane_nx;
  logic [WIDTH-1:0]  exp_word, diff;
  logic [POP_W-1:0]  pop;

  bert_gen #(.WIDTH(WIDTH)) u_gen (
    .clk(clk), .rst_n(rst_n), .start(start),
    .ready(tx_ready), .valid(tx_valid), .data(tx_data)
  );

  bert_sync u_sync (
    .clk(clk), .rst_n(rst_n), .clear(start),
    .in_valid(rx_valid), .in_bit(rx_data[0]),
    .locked(sync_lock), .exp_bit(exp_bit),
    .lock_evt(lock_evt), .slip_evt(slip_evt)
  );

  bert_lfsr_step #(.LEN(LANE_W), .TAP_A(TAP_HI), .TAP_B(TAP_LO)) u_ref_step (.state_i(wref_q), .state_o(wref_nx));
  bert_lfsr_step #(.LEN(LANE_W), .TAP_A(TAP_HI), .TAP_B(TAP_LO)) u_rx_step  (.state_i(rx_data[WIDTH-1:1]), .state_o(rx_lane_nx));

  assign rx_ready = 1'b1;
  assign chk_word = rx_valid && sync_lock;
  assign exp_word = {wref_q, exp_bit};
  assign diff     = rx_data ^ exp_word;

  always_comb begin
    pop = '0;
    for (int i = 0; i < WIDTH; i++) pop = pop + POP_W'(diff[i]);
  end

  // Word reference: loaded from the received lanes on the lock word.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         wref_q <= '0;
    else if (start)     wref_q <= '0;
    else if (lock_evt)  wref_q <= rx_lane_nx;
    else if (chk_word)  wref_q <= wref_nx;
  end

  bert_sat_acc #(.W(CW), .INC_W(POP_W)) u_err_acc (
    .clk(clk), .rst_n(rst_n), .clear(start), .en(chk_word), .inc(pop), .value(bit_err_count)
  );
  bert_sat_acc #(.W(CW), .INC_W(1)) u_word_acc (
    .clk(clk), .rst_n(rst_n), .clear(start), .en(chk_word), .inc(1'b1), .value(word_count)
  );
  bert_sat_acc #(.W(CW), .INC_W(1)) u_slip_acc (
    .clk(clk), .rst_n(rst_n), .clear(start), .en(slip_evt), .inc(1'b1), .value(slip_count)
  );
endmodule

// File: rtl/bert_core_sva.sv
module bert_core_sva #(
  parameter int WIDTH = 8,
  parameter int CW    = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [WIDTH-1:0] tx_data,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic             rx_valid,
  input logic             rx_ready,
  input logic             sync_lock,
  input logic [CW-1:0]    bit_err_count,
  input logic [CW-1:0]    slip_count,
  input logic [CW-1:0]    word_count
);
  assert_tx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !start) |=> $stable(tx_data));

  assert_rx_always_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready);

  assert_idle_no_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_valid && !start) |=> ($stable(sync_lock) && $stable(word_count) && $stable(slip_count)));

  assert_lock_needs_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_lock) |-> $past(rx_valid));

  assert_unlocked_no_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_lock && !start) |=> ($stable(bit_err_count) && $stable(word_count)));

  assert_slip_drops_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_lock && !start) |=> (slip_count == $past(slip_count)) || !sync_lock);

  assert_err_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (bit_err_count >= $past(bit_err_count)));
endmodule

bind bert_core bert_core_sva #(.WIDTH(WIDTH), .CW(CW)) u_bert_core_sva (
  .clk(clk), .rst_n(rst_n), .start(start), .tx_data(tx_data), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_ready(rx_ready), .sync_lock(sync_lock),
  .bit_err_count(bit_err_count), .slip_count(slip_count), .word_count(word_count)
);

// File: tb/test_bert_core.sv
module test_bert_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       tx_ready = 1'b0;
  logic [7:0] err_mask = 8'h00;
  logic [7:0] tx_data, rx_data;
  logic       tx_valid, rx_valid, rx_ready, sync_lock;
  logic [15:0] bit_err_count, slip_count, word_count;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    string tag;
    int    lock;
    int    errs;
    int    slips;
    int    words;
    int    txd;
  } exp_t;

  exp_t exp_q[$];

  always #5 clk = ~clk;

  // Loopback with per-word error injection
  assign rx_valid = tx_valid & tx_ready;
  assign rx_data  = tx_data ^ err_mask;

  bert_core i_bert_core (
    .clk(clk), .rst_n(rst_n), .start(start),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .sync_lock(sync_lock), .bit_err_count(bit_err_count),
    .slip_count(slip_count), .word_count(word_count)
  );

  task automatic check(input string tag, input int act, input int expv);
    n_tests++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, expv, expv);
    end
  endtask

  task automatic expect_state(input string tag, input int lock, input int errs,
                              input int slips, input int words, input int txd);
    exp_t e;
    e.tag = tag; e.lock = lock; e.errs = errs; e.slips = slips; e.words = words; e.txd = txd;
    exp_q.push_back(e);
  endtask

  // Monitor: compares queued expectations 1 ns after the falling edge.
  initial begin
    forever begin
      exp_t e;
      wait (exp_q.size() != 0);
      #1;
      e = exp_q.pop_front();
      check({e.tag, " lock"},  int'(sync_lock),     e.lock);
      check({e.tag, " errs"},  int'(bit_err_count), e.errs);
      check({e.tag, " slips"}, int'(slip_count),    e.slips);
      check({e.tag, " words"}, int'(word_count),    e.words);
      if (e.txd >= 0) check({e.tag, " tx_data"}, int'(tx_data), e.txd);
    end
  end

  task automatic send(input int n, input logic [7:0] m);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tx_ready = 1'b1;
      err_mask = m;
    end
    @(negedge clk);
    tx_ready = 1'b0;
    err_mask = 8'h00;
  endtask

  task automatic pulse_start(input logic with_ready);
    @(negedge clk);
    start    = 1'b1;
    tx_ready = with_ready;
    @(negedge clk);
    start    = 1'b0;
    tx_ready = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset tx_valid", int'(tx_valid), 0);
    expect_state("R1 reset", 0, 0, 0, 0, -1);
    rst_n = 1'b1;
    @(negedge clk);

    pulse_start(1'b0);
    check("R1 tx_valid after start", int'(tx_valid), 1);
    check("R4 rx_ready", int'(rx_ready), 1);
    expect_state("R2 first word", 0, 0, 0, 0, 8'hB4);
    repeat (4) @(negedge clk);
    expect_state("R3 stall holds word", 0, 0, 0, 0, 8'hB4);
    send(1, 8'h00);
    expect_state("R2 R3 second word", 0, 0, 0, 0, 8'h6A);

    send(21, 8'h00);
    expect_state("R5 no lock at 22 words", 0, 0, 0, 0, -1);
    send(1, 8'h00);
    expect_state("R5 lock at 23 words", 1, 0, 0, 0, -1);
    send(100, 8'h00);
    expect_state("R12 R7 clean run", 1, 0, 0, 100, -1);
    repeat (3) @(negedge clk);
    expect_state("R4 idle no change", 1, 0, 0, 100, -1);

    send(1, 8'hA0);
    expect_state("R7 two-bit error word", 1, 2, 0, 101, -1);
    send(3, 8'h01);
    expect_state("R8 three bit0 misses", 1, 5, 0, 104, -1);
    send(1, 8'h00);
    expect_state("R8 lock held", 1, 5, 0, 105, -1);
    send(4, 8'h01);
    expect_state("R9 slip on fourth miss", 0, 9, 1, 109, -1);
    send(22, 8'h00);
    expect_state("R6 R9 relock pending", 0, 9, 1, 109, -1);
    send(1, 8'h00);
    expect_state("R9 relocked", 1, 9, 1, 109, -1);

    // R11: start with a handshake in the same cycle
    pulse_start(1'b1);
    expect_state("R11 start clears and reseeds", 0, 0, 0, 0, 8'hB4);

    send(22, 8'hFE);
    expect_state("R6 unlocked errors ignored", 0, 0, 0, 0, -1);
    send(1, 8'h00);
    send(10, 8'h00);
    expect_state("R5 word ref recovered", 1, 0, 0, 10, -1);

    send(9400, 8'hFE);
    expect_state("R10 error count saturates", 1, 65535, 0, 9410, -1);

    repeat (3) @(negedge clk);
    wait (exp_q.size() == 0);
    #2;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule